// File: doc/BRIEF.md
# Twelve-Hour BCD Time-of-Day Counter with Alarm Match

This block keeps the time of day as seconds, minutes and hours in packed BCD, with an a.m./p.m. flag and a twelve-hour cycle. An external one-pulse-per-second tick advances it. Software reaches everything through a small byte-wide register port: it can load the time directly, program an alarm time and choose which fields take part in the match, select the compare mode and enable the toggling output.

When the compare mode is set to alarm, each tick that updates the time also compares the new time with the alarm registers. Only the enabled fields are compared, and the a.m./p.m. bit belongs to the hour field. On a hit the block sets a sticky interrupt request, and it can invert the level of a compare output pin. The clock keeps counting without a pause. The request stays set until the interrupt acknowledge input or a software write clears it.

Register map (byte-wide): 0 seconds, 1 minutes, 2 hours, 3 alarm seconds, 4 alarm minutes, 5 alarm hours, 6 control, 7 status. A seconds or minutes byte holds the tens digit in bits 6:4 and the units digit in bits 3:0. An hours byte holds the p.m. flag in bit 7 (1 = p.m.), the tens digit in bits 5:4 and the units digit in bits 3:0. The control byte holds the mode in bits 5:4, the output enable in bit 3, and the hour, minute and second compare enables in bits 2, 1 and 0. The status byte holds busy in bit 7 and the interrupt request in bit 0.

Top module: `rtc_alarm`

## Requirements
- R1: After reset every time and alarm register and the control byte read 0x00, `irq` is 0 and `cmp_out` is 0.
- R2: Seconds and minutes count 00 to 59 in BCD. A units digit of 9 carries into the tens digit, and 59 wraps to 00 and carries into the next field.
- R3: Hours run 12, 01, 02 … 11, 12. The p.m. flag (hours bit 7) inverts only on the step from 11:59:59 to 12:00:00, and 12:59:59 goes to 01:00:00 with the flag unchanged.
- R4: A write to address 0, 1 or 2 loads that field directly. If the write falls on the edge where a tick update would land, the written value is kept and the update is dropped.
- R5: A tick seen high at clock edge k updates the time at edge k+1. Between those edges, status bit 7 (busy) reads 1.
- R6: With mode 01 (control bits 5:4), an update whose new time equals the alarm in every enabled field sets `irq` and status bit 0. The hour comparison includes the p.m. flag.
- R7: Fields whose enable is 0 do not affect the match. With all three enables at 0, no match occurs.
- R8: With any mode other than 01, no update sets `irq` or changes `cmp_out`.
- R9: A match is judged only on the update edge. Writing a time equal to the alarm sets nothing until a tick produces a matching new time.
- R10: `irq` stays 1 until a one-cycle `irq_ack` pulse or a write to address 7 with bit 0 at 0 clears it. Further ticks without a match do not clear it.
- R11: With control bit 3 at 1, each match inverts `cmp_out`. With it at 0, a match leaves `cmp_out` unchanged while still setting `irq`.
- R12: Addresses 3 to 6 read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_1hz | input | 1 | One-pulse-per-second advance tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq_ack | input | 1 | Interrupt acknowledge, clears the request |
| irq | output | 1 | Sticky alarm interrupt request |
| cmp_out | output | 1 | Compare output, inverts on each enabled match |

## Verification
A wrong carry or digit state shows up at the time read-back on the first update after the faulty value: a wrong tens digit, a missed minute or hour carry, or a p.m. flag that flips at 12:59:59. A bad enable mask or hour comparison shows up on the same update edge: `irq` and `cmp_out` either move when they should stay or stay when they should move. The bench samples them one cycle after the tick. A lost or stuck request flag shows up on the next tick without a match or on the next acknowledge, and `cmp_out` exposes a toggle count that is off by one for as long as it is not corrected.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef struct packed {
    logic [2:0] tens;
    logic [3:0] ones;
  } bcd60_t;

  typedef struct packed {
    logic       pm;
    logic [1:0] tens;
    logic [3:0] ones;
  } bcd12_t;

  typedef struct packed {
    bcd12_t hr;
    bcd60_t mn;
    bcd60_t sc;
  } tod_t;

  typedef enum logic [ADDR_W-1:0] {
    RA_SEC  = 3'd0,
    RA_MIN  = 3'd1,
    RA_HR   = 3'd2,
    RA_CSEC = 3'd3,
    RA_CMIN = 3'd4,
    RA_CHR  = 3'd5,
    RA_CTRL = 3'd6,
    RA_STAT = 3'd7
  } reg_addr_e;

  localparam logic [1:0] MODE_ALARM = 2'b01;

  function automatic bcd60_t step60(input bcd60_t v);
    bcd60_t r;
    if (v.ones == 4'd9) begin
      r.tens = v.tens + 3'd1;
      r.ones = 4'd0;
    end else begin
      r.tens = v.tens;
      r.ones = v.ones + 4'd1;
    end
    return r;
  endfunction

  function automatic logic top60(input bcd60_t v);
    return (v.tens == 3'd5) && (v.ones == 4'd9);
  endfunction
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter
  import rtc_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             ld_sec,
  input  logic             ld_min,
  input  logic             ld_hr,
  input  logic [REG_W-1:0] ld_data,
  output tod_t             tod_q,
  output tod_t             tod_nx
);
  tod_t tod_d;
  logic sec_top, min_top;

  // advanced value of the current time
  always_comb begin
    sec_top = top60(tod_q.sc);
    min_top = top60(tod_q.mn);
    tod_nx  = tod_q;
    tod_nx.sc = sec_top ? '0 : step60(tod_q.sc);
    if (sec_top) begin
      tod_nx.mn = min_top ? '0 : step60(tod_q.mn);
      if (min_top) begin
        if (tod_q.hr.tens == 2'd1 && tod_q.hr.ones == 4'd2) begin
          tod_nx.hr.tens = 2'd0;
          tod_nx.hr.ones = 4'd1;
        end else if (tod_q.hr.ones == 4'd9) begin
          tod_nx.hr.tens = tod_q.hr.tens + 2'd1;
          tod_nx.hr.ones = 4'd0;
        end else begin
          tod_nx.hr.ones = tod_q.hr.ones + 4'd1;
        end
        if (tod_q.hr.tens == 2'd1 && tod_q.hr.ones == 4'd1)
          tod_nx.hr.pm = ~tod_q.hr.pm;
      end
    end
  end

  // next state: loads override an advance
  always_comb begin
    tod_d = tod_q;
    if (step)   tod_d = tod_nx;
    if (ld_sec) tod_d.sc = bcd60_t'(ld_data[6:0]);
    if (ld_min) tod_d.mn = bcd60_t'(ld_data[6:0]);
    if (ld_hr)  tod_d.hr = bcd12_t'({ld_data[7], ld_data[5:0]});
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tod_q <= '0;
    else        tod_q <= tod_d;

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld_sec && !ld_min && !ld_hr) |=> $stable(tod_q));

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_sec && !ld_min && !ld_hr && tod_q.sc == 7'h59) |=> (tod_q.sc == 7'h00));

  assert_hr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_sec && !ld_min && !ld_hr && tod_q.sc == 7'h59 && tod_q.mn == 7'h59
     && tod_q.hr.tens == 2'd1 && tod_q.hr.ones == 4'd2)
    |=> (tod_q.hr.tens == 2'd0 && tod_q.hr.ones == 4'd1 && $stable(tod_q.hr.pm)));
endmodule

// File: rtl/rtc_match_unit.sv
module rtc_match_unit
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  tod_t       tod_nx,
  input  tod_t       alarm,
  input  logic [2:0] fld_en,
  input  logic [1:0] mode,
  input  logic       out_en,
  input  logic       ack,
  input  logic       sw_clr,
  output logic       irq,
  output logic       cmp_out
);
  logic hit, irq_d, pin_d;
  logic eq_sc, eq_mn, eq_hr;

  always_comb begin
    eq_sc = (tod_nx.sc == alarm.sc) || !fld_en[0];
    eq_mn = (tod_nx.mn == alarm.mn) || !fld_en[1];
    eq_hr = (tod_nx.hr == alarm.hr) || !fld_en[2];
    hit   = step && (mode == MODE_ALARM) && (|fld_en) && eq_sc && eq_mn && eq_hr;
    irq_d = hit ? 1'b1 : ((ack || sw_clr) ? 1'b0 : irq);
    pin_d = (hit && out_en) ? ~cmp_out : cmp_out;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq     <= 1'b0;
      cmp_out <= 1'b0;
    end else begin
      irq     <= irq_d;
      cmp_out <= pin_d;
    end

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack && !sw_clr) |=> irq);

  assert_quiet_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_ALARM) |=> ($stable(cmp_out) && !$rose(irq)));

  assert_update_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(cmp_out) && !$rose(irq)));

  assert_no_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_en == 3'b000) |=> ($stable(cmp_out) && !$rose(irq)));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_alarm_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              irq_ack,
  output logic              irq,
  output logic              cmp_out
);
  logic       srst_n;
  logic       tick_q, tick_d;
  tod_t       alarm_q, alarm_d;
  logic [2:0] en_q, en_d;
  logic [1:0] mode_q, mode_d;
  logic       oen_q, oen_d;
  tod_t       tod_q, tod_nx;
  logic       wr_time, step, sw_clr;
  logic       ld_sec, ld_min, ld_hr;

  rtc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  always_comb begin
    ld_sec  = wr_en && (addr == RA_SEC);
    ld_min  = wr_en && (addr == RA_MIN);
    ld_hr   = wr_en && (addr == RA_HR);
    wr_time = ld_sec || ld_min || ld_hr;
    step    = tick_q && !wr_time;
    sw_clr  = wr_en && (addr == RA_STAT) && !wdata[0];
    tick_d  = tick_1hz;
    alarm_d = alarm_q;
    en_d    = en_q;
    mode_d  = mode_q;
    oen_d   = oen_q;
    if (wr_en) begin
      unique case (addr)
        RA_CSEC: alarm_d.sc = bcd60_t'(wdata[6:0]);
        RA_CMIN: alarm_d.mn = bcd60_t'(wdata[6:0]);
        RA_CHR:  alarm_d.hr = bcd12_t'({wdata[7], wdata[5:0]});
        RA_CTRL: begin
          mode_d = wdata[5:4];
          oen_d  = wdata[3];
          en_d   = wdata[2:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n)
    if (!srst_n) begin
      tick_q  <= 1'b0;
      alarm_q <= '0;
      en_q    <= '0;
      mode_q  <= '0;
      oen_q   <= 1'b0;
    end else begin
      tick_q  <= tick_d;
      alarm_q <= alarm_d;
      en_q    <= en_d;
      mode_q  <= mode_d;
      oen_q   <= oen_d;
    end

  rtc_tod_counter u_tod (
    .clk(clk), .rst_n(srst_n), .step(step),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hr(ld_hr), .ld_data(wdata),
    .tod_q(tod_q), .tod_nx(tod_nx)
  );

  rtc_match_unit u_match (
    .clk(clk), .rst_n(srst_n), .step(step), .tod_nx(tod_nx), .alarm(alarm_q),
    .fld_en(en_q), .mode(mode_q), .out_en(oen_q), .ack(irq_ack), .sw_clr(sw_clr),
    .irq(irq), .cmp_out(cmp_out)
  );

  always_comb begin
    unique case (addr)
      RA_SEC:  rdata = {1'b0, tod_q.sc};
      RA_MIN:  rdata = {1'b0, tod_q.mn};
      RA_HR:   rdata = {tod_q.hr.pm, 1'b0, tod_q.hr.tens, tod_q.hr.ones};
      RA_CSEC: rdata = {1'b0, alarm_q.sc};
      RA_CMIN: rdata = {1'b0, alarm_q.mn};
      RA_CHR:  rdata = {alarm_q.hr.pm, 1'b0, alarm_q.hr.tens, alarm_q.hr.ones};
      RA_CTRL: rdata = {2'b00, mode_q, oen_q, en_q};
      default: rdata = {tick_q, 6'b0, irq};
    endcase
  end

  assert_write_wins_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (ld_sec && tick_q) |=> (tod_q.sc == bcd60_t'($past(wdata[6:0]))));

  assert_busy_then_move_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (!tick_q && !wr_time) |=> $stable(tod_q));
endmodule

// File: tb/rtc_alarm_test.sv
module rtc_alarm_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq_ack = 1'b0;
  logic       irq, cmp_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic busy_seen;

  always #2 clk = ~clk;

  rtc_alarm uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_ack(irq_ack), .irq(irq), .cmp_out(cmp_out)
  );

  // {sec, min, hr, ticks, exp_sec, exp_min, exp_hr}
  localparam logic [55:0] VEC [9] = '{
    {8'h00, 8'h00, 8'h12, 8'd1, 8'h01, 8'h00, 8'h12},
    {8'h59, 8'h00, 8'h12, 8'd1, 8'h00, 8'h01, 8'h12},
    {8'h59, 8'h59, 8'h12, 8'd1, 8'h00, 8'h00, 8'h01},
    {8'h59, 8'h59, 8'h11, 8'd1, 8'h00, 8'h00, 8'h92},
    {8'h59, 8'h59, 8'h91, 8'd1, 8'h00, 8'h00, 8'h12},
    {8'h09, 8'h00, 8'h01, 8'd1, 8'h10, 8'h00, 8'h01},
    {8'h59, 8'h59, 8'h09, 8'd1, 8'h00, 8'h00, 8'h10},
    {8'h58, 8'h59, 8'h92, 8'd3, 8'h01, 8'h00, 8'h81},
    {8'h59, 8'h09, 8'h05, 8'd1, 8'h00, 8'h10, 8'h05}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    addr = 3'd7;
    #1 busy_seen = rdata[7];
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    wr(3'd0, s); wr(3'd1, m); wr(3'd2, h);
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic exp_pin;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 reg", v, 8'h00);
    end
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 cmp_out", {7'd0, cmp_out}, 8'h00);

    // R2 R3 counting table
    for (int i = 0; i < 9; i++) begin
      logic [55:0] e;
      e = VEC[i];
      set_time(e[55:48], e[47:40], e[39:32]);
      for (int t = 0; t < int'(e[31:24]); t++) do_tick();
      rd(3'd0, v); check("R2 sec", v, e[23:16]);
      rd(3'd1, v); check("R2 min", v, e[15:8]);
      rd(3'd2, v); check("R3 hr", v, e[7:0]);
    end

    // R5 busy between tick and update, then clear
    set_time(8'h20, 8'h00, 8'h03);
    do_tick();
    check("R5 busy", {7'd0, busy_seen}, 8'h01);
    rd(3'd7, v); check("R5 busy clear", v & 8'h80, 8'h00);
    rd(3'd0, v); check("R5 sec", v, 8'h21);

    // R4 write on the update edge wins
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    wr_en = 1'b1; addr = 3'd0; wdata = 8'h30;
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd0, v); check("R4 collide sec", v, 8'h30);
    rd(3'd1, v); check("R4 collide min", v, 8'h00);

    // R12 readback of alarm and control
    wr(3'd3, 8'h45); wr(3'd4, 8'h23); wr(3'd5, 8'h01);
    wr(3'd6, 8'h1F);
    rd(3'd3, v); check("R12 csec", v, 8'h45);
    rd(3'd4, v); check("R12 cmin", v, 8'h23);
    rd(3'd5, v); check("R12 chr", v, 8'h01);
    rd(3'd6, v); check("R12 ctrl", v, 8'h1F);

    // R6 R11 alarm match toggles output
    exp_pin = 1'b0;
    set_time(8'h44, 8'h23, 8'h01);
    do_tick();
    exp_pin = ~exp_pin;
    check("R6 irq", {7'd0, irq}, 8'h01);
    rd(3'd7, v); check("R6 stat irq", v & 8'h01, 8'h01);
    check("R11 pin", {7'd0, cmp_out}, {7'd0, exp_pin});
    rd(3'd0, v); check("R6 keeps counting", v, 8'h45);
    // R10 stays set over a non-matching tick
    do_tick();
    check("R10 sticky", {7'd0, irq}, 8'h01);
    check("R11 pin hold", {7'd0, cmp_out}, {7'd0, exp_pin});
    pulse_ack();
    check("R10 ack clear", {7'd0, irq}, 8'h00);
    // second match toggles back, then cleared by software write
    set_time(8'h44, 8'h23, 8'h01);
    do_tick();
    exp_pin = ~exp_pin;
    check("R11 second toggle", {7'd0, cmp_out}, {7'd0, exp_pin});
    check("R6 irq again", {7'd0, irq}, 8'h01);
    wr(3'd7, 8'h01);
    check("R10 write 1 ignored", {7'd0, irq}, 8'h01);
    wr(3'd7, 8'h00);
    check("R10 sw clear", {7'd0, irq}, 8'h00);

    // R6 p.m. flag part of hour compare
    wr(3'd5, 8'h81);
    set_time(8'h44, 8'h23, 8'h01);
    do_tick();
    check("R6 pm mismatch", {7'd0, irq}, 8'h00);
    check("R6 pm pin", {7'd0, cmp_out}, {7'd0, exp_pin});
    set_time(8'h44, 8'h23, 8'h81);
    do_tick();
    exp_pin = ~exp_pin;
    check("R6 pm match", {7'd0, irq}, 8'h01);
    check("R6 pm pin toggle", {7'd0, cmp_out}, {7'd0, exp_pin});
    pulse_ack();

    // R7 seconds only enabled
    wr(3'd6, 8'h19);
    set_time(8'h44, 8'h10, 8'h05);
    do_tick();
    exp_pin = ~exp_pin;
    check("R7 sec only", {7'd0, irq}, 8'h01);
    check("R7 pin", {7'd0, cmp_out}, {7'd0, exp_pin});
    pulse_ack();
    wr(3'd6, 8'h18);
    set_time(8'h44, 8'h23, 8'h81);
    do_tick();
    check("R7 none enabled", {7'd0, irq}, 8'h00);
    check("R7 none pin", {7'd0, cmp_out}, {7'd0, exp_pin});

    // R8 other modes
    wr(3'd6, 8'h2F);
    set_time(8'h44, 8'h23, 8'h81);
    do_tick();
    check("R8 mode 10", {7'd0, irq}, 8'h00);
    check("R8 pin", {7'd0, cmp_out}, {7'd0, exp_pin});
    wr(3'd6, 8'h0F);
    set_time(8'h44, 8'h23, 8'h81);
    do_tick();
    check("R8 mode 00", {7'd0, irq}, 8'h00);

    // R9 equal time written without a tick
    wr(3'd6, 8'h1F);
    set_time(8'h45, 8'h23, 8'h81);
    repeat (5) @(negedge clk);
    check("R9 no tick", {7'd0, irq}, 8'h00);
    check("R9 pin", {7'd0, cmp_out}, {7'd0, exp_pin});
    do_tick();
    check("R9 next tick", {7'd0, irq}, 8'h00);

    // R11 output disabled
    wr(3'd6, 8'h17);
    set_time(8'h44, 8'h23, 8'h81);
    do_tick();
    check("R11 irq no pin", {7'd0, irq}, 8'h01);
    check("R11 pin held", {7'd0, cmp_out}, {7'd0, exp_pin});
    pulse_ack();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule